// File: doc/BRIEF.md
# Prescaled Register-Programmed PWM Bank

This block produces one or two independent pulse-width-modulated outputs from a single functional clock. Each channel has a small register window: a control word carrying a 6-bit clock divider and a stop-style bit, a duty word carrying a 10-bit on-count and a force-high bit, and a 10-bit period word. Software writes these through a simple word-addressed port with a write strobe and reads them back on a combinational data bus.

A channel counts only while its enable input is high. Every output period lasts (divider+1)×(period+1) clocks, and the output is high at the start of the period for (divider+1)×(on-count) clocks. Values that software writes go into holding registers and reach the counters only at the next period boundary, so no period is ever cut short. When the enable drops, the control word picks between finishing the running period and forcing the output low at once.

Top module: `pwm_bank`

## Requirements
- R1: Within a channel window, byte offset 0x00 is control (bits 5:0 divider, bit 6 stop style), 0x04 is duty (bits 9:0 on-count, bit 10 force-high), and 0x08 is period (bits 9:0). Address bits 1:0 are ignored. Reads return the last accepted value with all other bits zero, and offset 0x0C reads zero.
- R2: A write to a channel while that channel's enable is low is ignored. The register keeps its earlier value.
- R3: While enabled, the output repeats with a period of exactly (divider+1)×(period+1) clock cycles.
- R4: Each period starts with the output high for (divider+1)×(on-count) cycles, and the output stays low for the rest of the period.
- R5: With duty bit 10 set, the output is high for every cycle of the period, whatever the on-count.
- R6: An on-count equal to or greater than period+1 gives an output that stays high for the whole period.
- R7: Register writes made during a period do not change that period. They take effect from the next period boundary.
- R8: With control bit 6 clear, dropping the enable lets the current period run to its end, and the output then stays low.
- R9: With control bit 6 set, the output is low from the first clock edge that samples the enable low.
- R10: The second channel uses the same layout at byte offset 0x10 (address bit 4 selects the channel), and it runs independently of the first.
- R11: After reset, every register reads zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NUM_CH | Per-channel run and write enable |
| wr_en | input | 1 | Write strobe, one cycle per word |
| addr | input | 5 | Byte address (bit 4 channel, bits 3:2 register) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| pwm_out | output | NUM_CH | Modulated outputs |

## Verification
The hardest case to reach from the ports is a write that lands inside a period, when the running period must still finish on the old values. To get there, the stimulus first locks onto a rising output edge, which marks a boundary. It then issues the write on the next cycle and counts the rest of that high phase before measuring the following period. The two stop styles are set up the same way: the enable is dropped a known number of cycles after the edge. Random divider, period and on-count settings on both channels, measured edge to edge, cover the timing formulas.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_DUTY = 2'd1,
      SEL_PER  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_bank_pkg::*;
#(
   parameter int PRE_W  = 6,
   parameter int CNT_W  = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              wr_i,
   input  reg_sel_e          sel_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rd_o,
   output logic [PRE_W-1:0]  cfg_pre_o,
   output logic              cfg_hard_o,
   output logic [CNT_W-1:0]  cfg_dc_o,
   output logic              cfg_full_o,
   output logic [CNT_W-1:0]  cfg_pv_o
);
   localparam int CTRL_W = PRE_W + 1;
   localparam int DUTY_W = CNT_W + 1;

   if (DATA_W <= DUTY_W || DATA_W <= CTRL_W) begin : g_bad_width
      $error("pwm_chan_regs: DATA_W too narrow for the fields");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [DUTY_W-1:0] duty_q;
   logic [CNT_W-1:0]  per_q;
   logic              unused_wbits;

   assign unused_wbits = ^wdata_i[DATA_W-1:DUTY_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         duty_q <= '0;
         per_q  <= '0;
      end else if (wr_i && en_i) begin
         unique case (sel_i)
            SEL_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
            SEL_DUTY: duty_q <= wdata_i[DUTY_W-1:0];
            SEL_PER:  per_q  <= wdata_i[CNT_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_o = '0;
      unique case (sel_i)
         SEL_CTRL: rd_o[CTRL_W-1:0] = ctrl_q;
         SEL_DUTY: rd_o[DUTY_W-1:0] = duty_q;
         SEL_PER:  rd_o[CNT_W-1:0]  = per_q;
         default:  rd_o = '0;
      endcase
   end

   assign cfg_pre_o  = ctrl_q[PRE_W-1:0];
   assign cfg_hard_o = ctrl_q[PRE_W];
   assign cfg_dc_o   = duty_q[CNT_W-1:0];
   assign cfg_full_o = duty_q[CNT_W];
   assign cfg_pv_o   = per_q;

   AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable({ctrl_q, duty_q, per_q})); // R2
endmodule

// File: rtl/pwm_chan_engine.sv
module pwm_chan_engine #(
   parameter int PRE_W = 6,
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [PRE_W-1:0] cfg_pre_i,
   input  logic             cfg_hard_i,
   input  logic [CNT_W-1:0] cfg_dc_i,
   input  logic             cfg_full_i,
   input  logic [CNT_W-1:0] cfg_pv_i,
   output logic             out_o
);
   logic             run_q;
   logic [PRE_W-1:0] pre_q, act_pre;
   logic [CNT_W-1:0] per_q, act_pv, act_dc;
   logic             act_full;
   logic             tick, last;

   assign tick = (pre_q == act_pre);
   assign last = tick && (per_q == act_pv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         pre_q    <= '0;
         per_q    <= '0;
         act_pre  <= '0;
         act_pv   <= '0;
         act_dc   <= '0;
         act_full <= 1'b0;
      end else if (!run_q) begin
         pre_q <= '0;
         per_q <= '0;
         if (en_i) begin
            run_q    <= 1'b1;
            act_pre  <= cfg_pre_i;
            act_pv   <= cfg_pv_i;
            act_dc   <= cfg_dc_i;
            act_full <= cfg_full_i;
         end
      end else if (!en_i && cfg_hard_i) begin
         run_q <= 1'b0;
         pre_q <= '0;
         per_q <= '0;
      end else if (tick) begin
         pre_q <= '0;
         if (last) begin
            per_q    <= '0;
            act_pre  <= cfg_pre_i;
            act_pv   <= cfg_pv_i;
            act_dc   <= cfg_dc_i;
            act_full <= cfg_full_i;
            if (!en_i) run_q <= 1'b0;
         end else begin
            per_q <= per_q + 1'b1;
         end
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign out_o = run_q && (act_full || (per_q < act_dc));

   AST_HARD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !en_i && cfg_hard_i) |=> !out_o); // R9
   AST_SOFT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !en_i && !cfg_hard_i && !last) |=> run_q); // R8
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !last) |=> $stable({act_pre, act_pv, act_dc, act_full})); // R7
   AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= act_pre); // R3
   AST_PER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      per_q <= act_pv); // R3
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int PRE_W  = 6,
   parameter int CNT_W  = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic              wr_en,
   input  logic [4:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam int CH_BIT = 4;

   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("pwm_bank: NUM_CH must be 1 or 2");
   end
   if (PRE_W < 1 || CNT_W < 1) begin : g_bad_cnt
      $error("pwm_bank: counter widths must be positive");
   end

   reg_sel_e          sel;
   logic              ch_sel;
   logic [1:0]        unused_abits;
   logic [DATA_W-1:0] rd_arr [NUM_CH];

   assign sel          = reg_sel_e'(addr[3:2]);
   assign ch_sel       = addr[CH_BIT];
   assign unused_abits = addr[1:0];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [PRE_W-1:0] c_pre;
      logic             c_hard;
      logic [CNT_W-1:0] c_dc;
      logic             c_full;
      logic [CNT_W-1:0] c_pv;

      pwm_chan_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .en_i       (ch_en[i]),
         .wr_i       (wr_en && (ch_sel == 1'(i))),
         .sel_i      (sel),
         .wdata_i    (wdata),
         .rd_o       (rd_arr[i]),
         .cfg_pre_o  (c_pre),
         .cfg_hard_o (c_hard),
         .cfg_dc_o   (c_dc),
         .cfg_full_o (c_full),
         .cfg_pv_o   (c_pv)
      );

      pwm_chan_engine #(.PRE_W(PRE_W), .CNT_W(CNT_W)) eng_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .en_i       (ch_en[i]),
         .cfg_pre_i  (c_pre),
         .cfg_hard_i (c_hard),
         .cfg_dc_i   (c_dc),
         .cfg_full_i (c_full),
         .cfg_pv_i   (c_pv),
         .out_o      (pwm_out[i])
      );
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_sel == 1'(i)) rdata = rd_arr[i];
      end
   end
endmodule

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ch_en = 2'b00;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  pwm_out;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   pwm_bank dut_i (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
   );

   function automatic int exp_period(int p, int pv);
      return (p + 1) * (pv + 1);
   endfunction

   function automatic int exp_high(int p, int pv, int dc, bit full);
      if (full || dc >= pv + 1) return (p + 1) * (pv + 1);
      return (p + 1) * dc;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_write(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 5'(a); wdata = 32'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(int a, output int d);
      @(negedge clk);
      addr = 5'(a);
      #1;
      d = int'(rdata);
   endtask

   task automatic cfg(int ch, int p, bit hard, int dc, bit full, int pv);
      do_write(ch * 16 + 0, (int'(hard) << 6) | p);
      do_write(ch * 16 + 4, (int'(full) << 10) | dc);
      do_write(ch * 16 + 8, pv);
   endtask

   task automatic sync_rise(int ch);
      int n = 0;
      @(negedge clk);
      while (pwm_out[ch] === 1'b1 && n < 70000) begin @(negedge clk); n++; end
      while (pwm_out[ch] !== 1'b1 && n < 140000) begin @(negedge clk); n++; end
   endtask

   task automatic measure(int ch, output int h, output int per);
      int l = 0;
      h = 0;
      sync_rise(ch);
      while (pwm_out[ch] === 1'b1 && h < 70000) begin h++; @(negedge clk); end
      while (pwm_out[ch] !== 1'b1 && l < 70000) begin l++; @(negedge clk); end
      per = h + l;
   endtask

   task automatic count_high(int ch, int n, output int hi);
      hi = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out[ch] === 1'b1) hi++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int d, h, per;
      void'($urandom(32'd715));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 out", int'(pwm_out), 0);
      for (int a = 0; a < 32; a += 4) begin
         do_read(a, d);
         chk("R11 reg zero", d, 0);
      end
      rst_n = 1'b1;
      ch_en = 2'b11;

      // R1 field masking and unmapped offset
      do_write(0, 32'hFFFF_FFC5); do_read(0, d); chk("R1 ctrl", d, 32'h45);
      do_write(4, -1);            do_read(4, d); chk("R1 duty", d, 32'h7FF);
      do_write(8, -1);            do_read(8, d); chk("R1 period", d, 32'h3FF);
      do_read(12, d);             chk("R1 unmapped", d, 0);
      do_write(16 + 9, 32'h12);   do_read(16 + 8, d); chk("R10 ch1 period lowbits", d, 32'h12);
      do_read(16 + 12, d);        chk("R1 ch1 unmapped", d, 0);
      do_read(0, d);              chk("R10 ch0 untouched", d, 32'h45);

      // R3 R4 R10 random settings on both channels
      cfg(0, 0, 0, 3, 0, 7);
      cfg(1, 1, 0, 2, 0, 4);
      measure(1, h, per);
      chk("R10 ch1 high", h, exp_high(1, 4, 2, 0));
      chk("R10 ch1 period", per, exp_period(1, 4));
      for (int t = 0; t < 20; t++) begin
         int ch = int'($urandom_range(0, 1));
         int p  = int'($urandom_range(0, 5));
         int pv = int'($urandom_range(1, 40));
         int dc = int'($urandom_range(1, pv));
         cfg(ch, p, 0, dc, 0, pv);
         measure(ch, h, per);
         chk("R4 high time", h, exp_high(p, pv, dc, 0));
         chk("R3 period", per, exp_period(p, pv));
      end

      // R7 write inside a period keeps the running period
      cfg(0, 0, 0, 10, 0, 19);
      measure(0, h, per);
      chk("R7 setup high", h, 10);
      sync_rise(0);
      h = 0;
      wr_en = 1'b1; addr = 5'd4; wdata = 32'd3;
      while (pwm_out[0] === 1'b1 && h < 1000) begin h++; @(negedge clk); wr_en = 1'b0; end
      wr_en = 1'b0;
      chk("R7 old period high", h, 10);
      measure(0, h, per);
      chk("R7 new period high", h, 3);
      chk("R7 new period length", per, 20);

      // R5 force-high flag
      cfg(0, 1, 0, 2, 1, 9);
      repeat (60) @(negedge clk);
      count_high(0, 80, h);
      chk("R5 full flag high", h, 80);
      // R6 on-count at and above period+1
      cfg(0, 0, 0, 10, 0, 9);
      repeat (40) @(negedge clk);
      count_high(0, 50, h);
      chk("R6 dc=pv+1 high", h, 50);
      cfg(0, 0, 0, 14, 0, 9);
      repeat (40) @(negedge clk);
      count_high(0, 50, h);
      chk("R6 dc>pv+1 high", h, 50);

      // R8 soft stop finishes the period
      cfg(0, 0, 0, 5, 0, 9);
      sync_rise(0);
      h = 1;
      @(negedge clk);
      if (pwm_out[0] === 1'b1) h++;
      ch_en[0] = 1'b0;
      @(negedge clk);
      while (pwm_out[0] === 1'b1 && h < 1000) begin h++; @(negedge clk); end
      chk("R8 high completes", h, 5);
      count_high(0, 40, h);
      chk("R8 stays low", h, 0);

      // R9 hard stop drops at once
      ch_en[0] = 1'b1;
      cfg(0, 0, 1, 5, 0, 9);
      sync_rise(0);
      ch_en[0] = 1'b0;
      @(negedge clk);
      chk("R9 immediate low", int'(pwm_out[0]), 0);
      count_high(0, 30, h);
      chk("R9 stays low", h, 0);

      // R2 writes ignored while disabled
      do_write(8, 32'h155);
      do_read(8, d);  chk("R2 period kept", d, 9);
      do_write(0, 32'h3);
      do_read(0, d);  chk("R2 ctrl kept", d, 32'h40);
      chk("R2 out low", int'(pwm_out[0]), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule